// File: doc/BRIEF.md
# Converter Output Blanking Formatter

This block stands between a pipelined 10-bit converter and the parallel output pins. It registers each converter word on the output clock. Two level controls can override that word. An active-low blanking request replaces video with a fixed black code. A power-down level forces the word to all zeros.

Blanking is meant to line up with the samples it covers. The converter word arrives after the converter's own pipeline latency, so the blanking request is held in a delay line whose depth equals that latency. Power-down does not go through that delay. It takes effect on the next clock edge, and it wins over blanking.

A valid flag tells downstream logic when the delay line again holds real control history. This happens a fixed number of edges after reset, or after power-down is released.

Top module: `adc_blank_fmt`

## Requirements
- R1: While power-down is low and no delayed blanking request is active, the word present on `raw_word` at a clock edge appears on `out_word` right after that edge, so one edge of latency.
- R2: When `pwr_dn` is high at a clock edge, `out_word` is all zeros after that edge. There is no pipeline delay.
- R3: When `blank_n` is low at edge k, `out_word` shows the black code from edge k+LATENCY-1 onward. The black code is negative full scale plus BLACK_OFFSET LSB. In straight binary, where 0 is negative full scale, it is 32 by default, which is bit 5 set.
- R4: A change of `blank_n` has no effect on `out_word` until exactly LATENCY edges have passed. Counting from the edge after the change, the old behaviour holds for LATENCY-1 edges and the new behaviour starts at edge LATENCY. This applies to both the falling and the rising direction.
- R5: Power-down has priority over blanking. With both active, `out_word` is zero.
- R6: Reset fills the blanking delay line with the pass-data state. Holding `blank_n` low through reset gives no black code during the first LATENCY-1 edges after reset is released.
- R7: `out_valid` is low during reset. It rises on the LATENCY-th edge after reset is released and stays high until the next reset or power-down.
- R8: `pwr_dn` high clears `out_valid` after the next edge. After `pwr_dn` falls, `out_valid` rises again on the LATENCY-th edge.
- R9: During synchronous reset (`rst` high, active high) `out_word` is all zeros and `out_valid` is low.
- R10: The delay LATENCY is an integer parameter of at least 1, with a default of 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Output clock |
| rst | input | 1 | Synchronous reset, active high |
| raw_word | input | 10 | Converter result word |
| blank_n | input | 1 | Blanking request, low substitutes the black code |
| pwr_dn | input | 1 | Power-down level, high forces zeros |
| out_word | output | 10 | Registered output word |
| out_valid | output | 1 | High once the blanking delay line is filled |

## Verification
The hardest situation to reach is one where the delay line's contents differ from the current `blank_n` level right at a boundary. Examples are the first edges after reset while `blank_n` is held low, or an edge where blanking and power-down overlap.

The stimulus handles this in a few ways. It holds `blank_n` low through reset and then counts edges one by one. It toggles `blank_n` in both directions and checks the edge just before the expected switch as well as the edge of the switch itself. It also raises power-down while a blanking request is still travelling through the delay line.

// File: rtl/adc_blank_fmt_pkg.sv
package adc_blank_fmt_pkg;

    typedef enum logic [1:0] {
        SRC_DATA  = 2'd0,
        SRC_BLACK = 2'd1,
        SRC_ZERO  = 2'd2
    } out_src_t;

    typedef struct packed {
        logic pwr_dn;
        logic blank_act;
    } ovr_t;

    // Power-down wins over blanking, blanking wins over data.
    function automatic out_src_t pick_src(input ovr_t o);
        if (o.pwr_dn)
            return SRC_ZERO;
        else if (o.blank_act)
            return SRC_BLACK;
        else
            return SRC_DATA;
    endfunction

    // Straight binary: code 0 is negative full scale.
    function automatic int unsigned black_code(input int unsigned offset);
        return offset;
    endfunction

endpackage

// File: rtl/blank_delay.sv
module blank_delay #(
    parameter int LATENCY = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic blank_n,
    output logic blank_act
);
    // chain[0] is the live input; chain[LATENCY-1] feeds the output register,
    // which adds the last edge of delay.
    logic [LATENCY-1:0] chain;

    assign chain[0] = blank_n;

    for (genvar g = 1; g < LATENCY; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                chain[g] <= 1'b1;
            else
                chain[g] <= chain[g-1];
        end
    end

    assign blank_act = ~chain[LATENCY-1];

endmodule

// File: rtl/fill_tracker.sv
module fill_tracker #(
    parameter int LATENCY = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_dn,
    output logic valid
);
    localparam int CW = $clog2(LATENCY + 1);
    localparam logic [CW-1:0] FULL = CW'(LATENCY);

    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_nx;

    always_comb begin
        cnt_nx = (cnt == FULL) ? cnt : cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || pwr_dn) begin
            cnt   <= '0;
            valid <= 1'b0;
        end else begin
            cnt   <= cnt_nx;
            valid <= (cnt_nx == FULL);
        end
    end

    assert_pd_invalid_R8: assert property (@(posedge clk) disable iff (rst)
        pwr_dn |=> !valid);

    assert_valid_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (valid && !pwr_dn) |=> valid);

endmodule

// File: rtl/out_stage.sv
module out_stage
    import adc_blank_fmt_pkg::*;
#(
    parameter int DATA_W       = 10,
    parameter int BLACK_OFFSET = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] raw_word,
    input  ovr_t              ovr,
    output logic [DATA_W-1:0] out_word
);
    localparam logic [DATA_W-1:0] BLACK = DATA_W'(black_code(BLACK_OFFSET));

    out_src_t            src;
    logic [DATA_W-1:0]   nxt;

    always_comb begin
        src = pick_src(ovr);
        unique case (src)
            SRC_ZERO:  nxt = '0;
            SRC_BLACK: nxt = BLACK;
            default:   nxt = raw_word;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            out_word <= '0;
        else
            out_word <= nxt;
    end

    assert_pd_zero_R2: assert property (@(posedge clk) disable iff (rst)
        ovr.pwr_dn |=> (out_word == '0));

    assert_black_code_R3: assert property (@(posedge clk) disable iff (rst)
        (!ovr.pwr_dn && ovr.blank_act) |=> (out_word == BLACK));

    assert_pass_data_R1: assert property (@(posedge clk) disable iff (rst)
        (!ovr.pwr_dn && !ovr.blank_act) |=> (out_word == $past(raw_word)));

endmodule

// File: rtl/adc_blank_fmt.sv
module adc_blank_fmt
    import adc_blank_fmt_pkg::*;
#(
    parameter int DATA_W       = 10,
    parameter int LATENCY      = 6,
    parameter int BLACK_OFFSET = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] raw_word,
    input  logic              blank_n,
    input  logic              pwr_dn,
    output logic [DATA_W-1:0] out_word,
    output logic              out_valid
);
    ovr_t ovr;
    logic blank_act;

    initial begin
        assert_latency_R10: assert (LATENCY >= 1);
    end

    blank_delay #(.LATENCY(LATENCY)) u_delay (
        .clk       (clk),
        .rst       (rst),
        .blank_n   (blank_n),
        .blank_act (blank_act)
    );

    always_comb begin
        ovr.pwr_dn    = pwr_dn;
        ovr.blank_act = blank_act;
    end

    out_stage #(.DATA_W(DATA_W), .BLACK_OFFSET(BLACK_OFFSET)) u_out (
        .clk      (clk),
        .rst      (rst),
        .raw_word (raw_word),
        .ovr      (ovr),
        .out_word (out_word)
    );

    fill_tracker #(.LATENCY(LATENCY)) u_fill (
        .clk    (clk),
        .rst    (rst),
        .pwr_dn (pwr_dn),
        .valid  (out_valid)
    );

    assert_pd_wins_R5: assert property (@(posedge clk) disable iff (rst)
        (pwr_dn && blank_act) |=> (out_word == '0 && !out_valid));

endmodule

// File: tb/adc_blank_fmt_test.sv
module adc_blank_fmt_test;
    localparam int W   = 10;
    localparam int L   = 6;
    localparam logic [W-1:0] BLK = 10'd32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] raw_word = '0;
    logic         blank_n = 1'b1;
    logic         pwr_dn = 1'b0;
    logic [W-1:0] out_word;
    logic         out_valid;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    adc_blank_fmt uut (
        .clk(clk), .rst(rst), .raw_word(raw_word), .blank_n(blank_n),
        .pwr_dn(pwr_dn), .out_word(out_word), .out_valid(out_valid)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk_word(input string req, input logic [W-1:0] exp);
        n_run++;
        if (out_word !== exp) begin
            n_fail++;
            $display("FAIL %s out_word actual=%0d expected=%0d", req, out_word, exp);
        end
    endtask

    task automatic chk_valid(input string req, input logic exp);
        n_run++;
        if (out_valid !== exp) begin
            n_fail++;
            $display("FAIL %s out_valid actual=%0b expected=%0b", req, out_valid, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; blank_n = 1'b1; pwr_dn = 1'b0;
        tick(); tick();
        rst = 1'b0;
        for (int i = 0; i < L; i++) tick();
    endtask

    // R9 and R7: reset state, then fill
    task automatic t_reset_fill();
        rst = 1'b1; raw_word = 10'h2AA;
        tick(); tick();
        chk_word("R9", '0);
        chk_valid("R9", 1'b0);
        rst = 1'b0;
        for (int i = 1; i < L; i++) tick();
        chk_valid("R7", 1'b0);
        tick();
        chk_valid("R7", 1'b1);
        for (int i = 0; i < 4; i++) tick();
        chk_valid("R7", 1'b1);
    endtask

    // R1: data passes with one edge of latency
    task automatic t_pass();
        logic [W-1:0] pats [5] = '{10'h000, 10'h3FF, 10'h155, 10'h2AA, 10'h021};
        for (int i = 0; i < 5; i++) begin
            raw_word = pats[i];
            tick();
            chk_word("R1", pats[i]);
        end
    endtask

    // R3/R4: blanking alignment, both directions
    task automatic t_blank_align();
        raw_word = 10'h1C3;
        blank_n = 1'b0;
        for (int i = 1; i < L; i++) tick();
        chk_word("R4", 10'h1C3);
        tick();
        chk_word("R3", BLK);
        raw_word = 10'h0F0;
        tick();
        chk_word("R3", BLK);
        blank_n = 1'b1;
        for (int i = 1; i < L; i++) tick();
        chk_word("R4", BLK);
        tick();
        chk_word("R4", 10'h0F0);
    endtask

    // R2/R8: power-down forces zero, clears valid, refill
    task automatic t_pd();
        raw_word = 10'h3A5;
        pwr_dn = 1'b1;
        tick();
        chk_word("R2", '0);
        chk_valid("R8", 1'b0);
        tick();
        chk_word("R2", '0);
        pwr_dn = 1'b0;
        tick();
        chk_word("R2", 10'h3A5);
        for (int i = 1; i < L - 1; i++) tick();
        chk_valid("R8", 1'b0);
        tick();
        chk_valid("R8", 1'b1);
    endtask

    // R5: power-down beats a pending and an active blank
    task automatic t_pd_priority();
        raw_word = 10'h111;
        blank_n = 1'b0;
        for (int i = 0; i < L; i++) tick();
        chk_word("R5", BLK);
        pwr_dn = 1'b1;
        tick();
        chk_word("R5", '0);
        pwr_dn = 1'b0;
        tick();
        chk_word("R5", BLK);
        blank_n = 1'b1;
        for (int i = 0; i < L; i++) tick();
        chk_word("R5", 10'h111);
    endtask

    // R6: delay line starts in pass state after reset
    task automatic t_reset_pass_state();
        rst = 1'b1; blank_n = 1'b0; raw_word = 10'h155;
        tick(); tick();
        rst = 1'b0;
        for (int i = 1; i < L; i++) begin
            tick();
            chk_word("R6", 10'h155);
        end
        tick();
        chk_word("R6", BLK);
        blank_n = 1'b1;
        for (int i = 0; i < L; i++) tick();
    endtask

    initial begin
        t_reset_fill();
        t_pass();
        t_blank_align();
        t_pd();
        t_pd_priority();
        t_reset_pass_state();
        do_reset();
        chk_valid("R10", 1'b1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #100000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule